// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block sequences a processor subsystem into and out of three reduced-power tiers: light sleep, deep sleep and full power-off. Software selects a tier on `lp_mode` and then pulses `wfi_strobe`. The controller then drops the matching enables: the core clock, the analog domain, the watchdog-oscillator and brown-out keep-alives, and the main power domain. It holds them low until a wake source that is valid for that tier appears. Each tier listens to a different set of wake sources. Light sleep returns on an interrupt or a reset request. Deep sleep returns on an enabled general wake pin or on the real-time-clock match. Power-off returns only on the dedicated active-low wake pin or the clock match.

The states are RUN, SLEEP, DEEP, OFF and PWRUP. Their transitions are:
- RUN to SLEEP, DEEP or OFF on a strobe, according to the mode request.
- SLEEP to RUN on a sleep wake source.
- DEEP to RUN on a deep-sleep wake source.
- OFF to PWRUP on a power-off wake source.
- PWRUP to RUN unconditionally after one cycle.

On exit from power-off the block forces the clock source to the internal RC oscillator through `irc_force`. A wake-cause register reports which source ended the last low-power period.

Top module: `lpw_ctrl`

## Requirements
- R1: After reset the controller is in RUN with every enable high, `irc_force` high and `wake_cause` 0.
- R2: In RUN, a `wfi_strobe` sampled on a clock edge enters SLEEP for `lp_mode` 2'b01, DEEP for 2'b10 and OFF for 2'b11, effective after that edge. With `lp_mode` 2'b00 the strobe is ignored.
- R3: In SLEEP only `core_clk_en` is low. The analog, watchdog, brown-out and main enables stay high.
- R4: In SLEEP, `irq_pending` or `rst_req` returns to RUN on the next edge. `wake_cause` becomes 1 for an interrupt or 2 for a reset request, and the reset request wins when both are present. Pin and clock-match inputs are ignored in SLEEP.
- R5: In DEEP, the core clock and analog enables are low. `wdt_osc_en` and `bod_en` equal `keep_wdt` and `keep_bod` as sampled at entry, and later changes to those inputs have no effect.
- R6: In DEEP, only `rtc_match` or a pin set in both `gpio_wake` and `gpio_wake_en` returns to RUN on the next edge. The cause is 4 for the clock match and 3 for a pin, and the match wins. Interrupts, reset requests and masked pins are ignored.
- R7: In OFF, all five enables are low.
- R8: In OFF, `rtc_match` or a low level on `wake_n` ends the state. `wake_n` passes through two synchroniser flops, so a level applied before edge k is acted on at edge k+2. The controller then spends one cycle in PWRUP (main, analog, watchdog and brown-out enables high, core clock low) before RUN. The cause is 5 for the wake pin and 4 for the match, and the pin wins. Interrupts and general pins are ignored.
- R9: `irc_force` clears at every mode entry and sets on exit from OFF.
- R10: `wake_cause` clears to 0 at every mode entry and otherwise holds its value until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_mode | input | 2 | Requested tier: 00 none, 01 sleep, 10 deep, 11 off |
| wfi_strobe | input | 1 | Wait-for-interrupt strobe that triggers entry |
| irq_pending | input | 1 | Pending interrupt |
| rst_req | input | 1 | Reset request line |
| gpio_wake | input | NPINS | General wake-capable pins, active high |
| gpio_wake_en | input | NPINS | Per-pin wake enables |
| keep_wdt | input | 1 | Keep watchdog oscillator alive in deep sleep |
| keep_bod | input | 1 | Keep brown-out detector alive in deep sleep |
| rtc_match | input | 1 | Real-time-clock match event |
| wake_n | input | 1 | Dedicated wake pin, active low, asynchronous |
| core_clk_en | output | 1 | Core clock enable |
| analog_en | output | 1 | Analog domain enable |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| bod_en | output | 1 | Brown-out detector enable |
| main_pwr_en | output | 1 | Main power domain enable |
| irc_force | output | 1 | Clock source forced to internal RC oscillator |
| wake_cause | output | 3 | Source that ended the last low-power period |

## Verification
The bench targets the places where the tiers differ. It presents an interrupt during deep sleep, an interrupt and a general pin during power-off, and clock-match and pin inputs during light sleep. A controller that shared one wake set across tiers would leave its state on one of these inputs. The bench also presents a pin that is active but masked, which a controller that ignored the mask would wake on. The keep-alive inputs are toggled in mid deep sleep; a design that failed to capture them at entry would let `wdt_osc_en` or `bod_en` follow them. The power-off exit is timed cycle by cycle, which catches a missing synchroniser stage, a skipped PWRUP cycle or a wrong cause priority when the wake pin and the clock match arrive together.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_SLEEP = 2'b01,
        REQ_DEEP  = 2'b10,
        REQ_OFF   = 2'b11
    } lp_req_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_DEEP  = 3'd2,
        ST_OFF   = 3'd3,
        ST_PWRUP = 3'd4
    } lp_state_e;

    typedef enum logic [2:0] {
        WC_NONE    = 3'd0,
        WC_IRQ     = 3'd1,
        WC_RESET   = 3'd2,
        WC_PIN     = 3'd3,
        WC_RTC     = 3'd4,
        WC_WAKEPIN = 3'd5
    } wake_cause_e;

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lpw_wake_eval.sv
module lpw_wake_eval
    import lpw_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  lp_state_e        state,
    input  logic             irq_pending,
    input  logic             rst_req,
    input  logic [NPINS-1:0] gpio_wake,
    input  logic [NPINS-1:0] gpio_wake_en,
    input  logic             rtc_match,
    input  logic             wakepin_act,
    output logic             wake,
    output wake_cause_e      cause
);

    logic pin_hit;
    assign pin_hit = |(gpio_wake & gpio_wake_en);

    always_comb begin
        wake  = 1'b0;
        cause = WC_NONE;
        unique case (state)
            ST_SLEEP: begin
                if (rst_req) begin
                    wake  = 1'b1;
                    cause = WC_RESET;
                end else if (irq_pending) begin
                    wake  = 1'b1;
                    cause = WC_IRQ;
                end
            end
            ST_DEEP: begin
                if (rtc_match) begin
                    wake  = 1'b1;
                    cause = WC_RTC;
                end else if (pin_hit) begin
                    wake  = 1'b1;
                    cause = WC_PIN;
                end
            end
            ST_OFF: begin
                if (wakepin_act) begin
                    wake  = 1'b1;
                    cause = WC_WAKEPIN;
                end else if (rtc_match) begin
                    wake  = 1'b1;
                    cause = WC_RTC;
                end
            end
            ST_RUN, ST_PWRUP: begin
                wake  = 1'b0;
                cause = WC_NONE;
            end
            default: begin
                wake  = 1'b0;
                cause = WC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
    import lpw_pkg::*;
#(
    parameter int NPINS       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lp_mode,
    input  logic             wfi_strobe,
    input  logic             irq_pending,
    input  logic             rst_req,
    input  logic [NPINS-1:0] gpio_wake,
    input  logic [NPINS-1:0] gpio_wake_en,
    input  logic             keep_wdt,
    input  logic             keep_bod,
    input  logic             rtc_match,
    input  logic             wake_n,
    output logic             core_clk_en,
    output logic             analog_en,
    output logic             wdt_osc_en,
    output logic             bod_en,
    output logic             main_pwr_en,
    output logic             irc_force,
    output logic [2:0]       wake_cause
);

    lp_state_e   state_q, state_d;
    wake_cause_e cause_q, cause_w;
    logic        wake_w, wakepin_act, entering;
    logic        keep_wdt_q, keep_bod_q, irc_q;

    lpw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~wake_n),
        .q     (wakepin_act)
    );

    lpw_wake_eval #(.NPINS(NPINS)) u_eval (
        .state        (state_q),
        .irq_pending  (irq_pending),
        .rst_req      (rst_req),
        .gpio_wake    (gpio_wake),
        .gpio_wake_en (gpio_wake_en),
        .rtc_match    (rtc_match),
        .wakepin_act  (wakepin_act),
        .wake         (wake_w),
        .cause        (cause_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_strobe) begin
                    unique case (lp_req_e'(lp_mode))
                        REQ_SLEEP: state_d = ST_SLEEP;
                        REQ_DEEP:  state_d = ST_DEEP;
                        REQ_OFF:   state_d = ST_OFF;
                        REQ_NONE:  state_d = ST_RUN;
                        default:   state_d = ST_RUN;
                    endcase
                end
            end
            ST_SLEEP, ST_DEEP: if (wake_w) state_d = ST_RUN;
            ST_OFF:            if (wake_w) state_d = ST_PWRUP;
            ST_PWRUP:          state_d = ST_RUN;
            default:           state_d = ST_RUN;
        endcase
    end

    assign entering = (state_q == ST_RUN) && (state_d != ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            cause_q    <= WC_NONE;
            irc_q      <= 1'b1;
            keep_wdt_q <= 1'b0;
            keep_bod_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (entering) begin
                cause_q    <= WC_NONE;
                irc_q      <= 1'b0;
                keep_wdt_q <= keep_wdt;
                keep_bod_q <= keep_bod;
            end else if (wake_w) begin
                cause_q <= cause_w;
                if (state_q == ST_OFF) irc_q <= 1'b1;
            end
        end
    end

    always_comb begin
        core_clk_en = 1'b1;
        analog_en   = 1'b1;
        wdt_osc_en  = 1'b1;
        bod_en      = 1'b1;
        main_pwr_en = 1'b1;
        unique case (state_q)
            ST_RUN: ;
            ST_SLEEP: core_clk_en = 1'b0;
            ST_DEEP: begin
                core_clk_en = 1'b0;
                analog_en   = 1'b0;
                wdt_osc_en  = keep_wdt_q;
                bod_en      = keep_bod_q;
            end
            ST_OFF: begin
                core_clk_en = 1'b0;
                analog_en   = 1'b0;
                wdt_osc_en  = 1'b0;
                bod_en      = 1'b0;
                main_pwr_en = 1'b0;
            end
            ST_PWRUP: core_clk_en = 1'b0;
            default: ;
        endcase
    end

    assign irc_force  = irc_q;
    assign wake_cause = cause_q;

endmodule

// File: rtl/lpw_ctrl_chk.sv
module lpw_ctrl_chk
    import lpw_pkg::*;
#(
    parameter int NPINS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       state,
    input logic             irq_pending,
    input logic             rst_req,
    input logic [NPINS-1:0] gpio_wake,
    input logic [NPINS-1:0] gpio_wake_en,
    input logic             rtc_match,
    input logic             core_clk_en,
    input logic             analog_en,
    input logic             wdt_osc_en,
    input logic             bod_en,
    input logic             main_pwr_en,
    input logic             irc_force,
    input logic [2:0]       wake_cause
);

    p_sleep_only_core_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> (!core_clk_en && analog_en && wdt_osc_en && bod_en && main_pwr_en));

    p_sleep_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && (irq_pending || rst_req)) |=> (state == ST_RUN && core_clk_en));

    p_deep_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && !rtc_match && ((gpio_wake & gpio_wake_en) == '0)) |=> (state == ST_DEEP));

    p_off_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr_en |-> (!core_clk_en && !analog_en && !wdt_osc_en && !bod_en));

    p_pwrup_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_pwr_en) |-> (!core_clk_en && irc_force));

    p_cause_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && $past(core_clk_en)) |-> $stable(wake_cause));

    p_entry_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> (wake_cause == 3'd0 && !irc_force));

endmodule

bind lpw_ctrl lpw_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .irq_pending  (irq_pending),
    .rst_req      (rst_req),
    .gpio_wake    (gpio_wake),
    .gpio_wake_en (gpio_wake_en),
    .rtc_match    (rtc_match),
    .core_clk_en  (core_clk_en),
    .analog_en    (analog_en),
    .wdt_osc_en   (wdt_osc_en),
    .bod_en       (bod_en),
    .main_pwr_en  (main_pwr_en),
    .irc_force    (irc_force),
    .wake_cause   (wake_cause)
);

// File: tb/lpw_ctrl_tb_top.sv
module lpw_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 12;

    typedef struct packed {
        logic       core;
        logic       analog;
        logic       wdt;
        logic       bod;
        logic       main;
        logic       irc;
        logic [2:0] cause;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       lp_mode = 2'b00;
    logic             wfi_strobe = 1'b0;
    logic             irq_pending = 1'b0;
    logic             rst_req = 1'b0;
    logic [NPINS-1:0] gpio_wake = '0;
    logic [NPINS-1:0] gpio_wake_en = '0;
    logic             keep_wdt = 1'b0;
    logic             keep_bod = 1'b0;
    logic             rtc_match = 1'b0;
    logic             wake_n = 1'b1;
    logic             core_clk_en, analog_en, wdt_osc_en, bod_en, main_pwr_en, irc_force;
    logic [2:0]       wake_cause;

    int    n_checks = 0;
    int    n_fail   = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lpw_ctrl #(.NPINS(NPINS), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .wfi_strobe(wfi_strobe),
        .irq_pending(irq_pending), .rst_req(rst_req), .gpio_wake(gpio_wake),
        .gpio_wake_en(gpio_wake_en), .keep_wdt(keep_wdt), .keep_bod(keep_bod),
        .rtc_match(rtc_match), .wake_n(wake_n), .core_clk_en(core_clk_en),
        .analog_en(analog_en), .wdt_osc_en(wdt_osc_en), .bod_en(bod_en),
        .main_pwr_en(main_pwr_en), .irc_force(irc_force), .wake_cause(wake_cause)
    );

    function automatic exp_t e_run(logic [2:0] c, logic irc);
        return '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, irc, c};
    endfunction
    function automatic exp_t e_sleep(logic [2:0] c, logic irc);
        return '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, irc, c};
    endfunction
    function automatic exp_t e_deep(logic w, logic b, logic [2:0] c);
        return '{1'b0, 1'b0, w, b, 1'b1, 1'b0, c};
    endfunction
    function automatic exp_t e_off();
        return '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0};
    endfunction
    function automatic exp_t e_pwrup(logic [2:0] c);
        return '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, c};
    endfunction

    // Driver: inputs already set at a falling edge; push what must show after the next rising edge.
    task automatic cyc(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        wfi_strobe = 1'b0; irq_pending = 1'b0; rst_req = 1'b0;
        rtc_match = 1'b0; gpio_wake = '0;
    endtask

    // Monitor: compare a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{core_clk_en, analog_en, wdt_osc_en, bod_en, main_pwr_en, irc_force, wake_cause};
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual core=%b ana=%b wdt=%b bod=%b main=%b irc=%b cause=%0d expected core=%b ana=%b wdt=%b bod=%b main=%b irc=%b cause=%0d",
                        t, a.core, a.analog, a.wdt, a.bod, a.main, a.irc, a.cause,
                        e.core, e.analog, e.wdt, e.bod, e.main, e.irc, e.cause);
                end
            end
        end
    end

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(e_run(3'd0, 1'b1), "R1 reset state");

        lp_mode = 2'b00; wfi_strobe = 1'b1;
        cyc(e_run(3'd0, 1'b1), "R2 mode 00 ignored");

        lp_mode = 2'b01;
        cyc(e_sleep(3'd0, 1'b0), "R2 R9 enter sleep");
        idle();
        cyc(e_sleep(3'd0, 1'b0), "R3 sleep holds");
        gpio_wake = '1; gpio_wake_en = '1; rtc_match = 1'b1;
        cyc(e_sleep(3'd0, 1'b0), "R4 pins and match ignored in sleep");
        idle(); irq_pending = 1'b1;
        cyc(e_run(3'd1, 1'b0), "R4 interrupt wake");
        idle();
        cyc(e_run(3'd1, 1'b0), "R10 cause held in run");

        lp_mode = 2'b01; wfi_strobe = 1'b1;
        cyc(e_sleep(3'd0, 1'b0), "R10 cause cleared at entry");
        idle(); irq_pending = 1'b1; rst_req = 1'b1;
        cyc(e_run(3'd2, 1'b0), "R4 reset request priority");

        idle(); lp_mode = 2'b10; wfi_strobe = 1'b1; keep_wdt = 1'b1; keep_bod = 1'b0;
        cyc(e_deep(1'b1, 1'b0, 3'd0), "R5 deep entry keep bits");
        idle(); keep_wdt = 1'b0; keep_bod = 1'b1;
        cyc(e_deep(1'b1, 1'b0, 3'd0), "R5 keep bits frozen");
        irq_pending = 1'b1; rst_req = 1'b1;
        cyc(e_deep(1'b1, 1'b0, 3'd0), "R6 interrupt ignored in deep");
        idle(); gpio_wake_en = '0; gpio_wake_en[3] = 1'b1; gpio_wake[5] = 1'b1;
        cyc(e_deep(1'b1, 1'b0, 3'd0), "R6 masked pin ignored");
        gpio_wake_en[5] = 1'b1;
        cyc(e_run(3'd3, 1'b0), "R6 enabled pin wake");

        idle(); lp_mode = 2'b10; wfi_strobe = 1'b1; keep_wdt = 1'b0; keep_bod = 1'b1;
        cyc(e_deep(1'b0, 1'b1, 3'd0), "R5 deep entry other keep bits");
        idle(); rtc_match = 1'b1; gpio_wake[5] = 1'b1;
        cyc(e_run(3'd4, 1'b0), "R6 match priority over pin");

        idle(); lp_mode = 2'b11; wfi_strobe = 1'b1;
        cyc(e_off(), "R7 off entry");
        idle(); irq_pending = 1'b1; rst_req = 1'b1; gpio_wake = '1; gpio_wake_en = '1;
        cyc(e_off(), "R8 interrupt and pins ignored in off");
        idle(); wake_n = 1'b0;
        cyc(e_off(), "R8 sync stage one");
        cyc(e_off(), "R8 sync stage two");
        cyc(e_pwrup(3'd5), "R8 R9 power-up cycle");
        cyc(e_run(3'd5, 1'b1), "R8 run after power-up");
        wake_n = 1'b1;
        cyc(e_run(3'd5, 1'b1), "R9 irc held in run");
        cyc(e_run(3'd5, 1'b1), "R10 cause held");

        lp_mode = 2'b11; wfi_strobe = 1'b1;
        cyc(e_off(), "R7 R9 off entry clears irc");
        idle(); rtc_match = 1'b1;
        cyc(e_pwrup(3'd4), "R8 match wake");
        idle();
        cyc(e_run(3'd4, 1'b1), "R8 run after match wake");

        lp_mode = 2'b11; wfi_strobe = 1'b1;
        cyc(e_off(), "R7 off entry again");
        idle(); wake_n = 1'b0;
        cyc(e_off(), "R8 sync one");
        cyc(e_off(), "R8 sync two");
        rtc_match = 1'b1;
        cyc(e_pwrup(3'd5), "R8 wake pin priority over match");
        idle(); wake_n = 1'b1;
        cyc(e_run(3'd5, 1'b1), "R8 back to run");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule